// File: doc/BRIEF.md
# Adder-Ring Accumulator Datapath

This block is the arithmetic half of a small accumulator machine. A chain of full adders, cut into 4-bit slices, produces a sum every cycle, and the accumulator register takes that sum on every clock edge. The selected operation sets only the three inputs of the adder: the A operand, the B operand and the carry-in. Holding, clearing, incrementing, adding, adding with a carry of one and loading are all forms of one addition.

A second register, the operand register, feeds B. It can keep its value, fill with ones, capture the memory data word, or invert itself. A sequencer outside the block uses it to stage the operand. To decrement, the sequencer fills the operand register with ones and then adds. To subtract a memory word, it captures the word, inverts it, and then adds with a carry of one. No subtractor or decrementer exists anywhere in the block.

Both registers update on the same edge. The accumulator therefore always uses the value the operand register held before that edge.

Top module: `acc_datapath`

## Requirements
- R1: While `rst_n` is low, `acc_q` and `b_q` are 0 and `acc_zero` is 1.
- R2: With `op_sel` = 0 (hold), `acc_q` keeps its value across the edge.
- R3: With `op_sel` = 1 (clear), `acc_q` becomes 0 after the edge.
- R4: With `op_sel` = 2 (increment), `acc_q` becomes `acc_q`+1 modulo 256. The carry ripples from the low slice into the high slice (0x0F gives 0x10), and 0xFF wraps to 0x00.
- R5: With `op_sel` = 4 (add), `acc_q` becomes `acc_q`+`b_q` modulo 256, and the carry out of bit 7 is dropped.
- R6: With `op_sel` = 5 (add with carry-in one), `acc_q` becomes `acc_q`+`b_q`+1 modulo 256. When `b_q` holds the inverted memory word, this is the accumulator minus that word.
- R7: With `op_sel` = 6 (load), `acc_q` becomes `b_q`.
- R8: `bmode_sel` sets the next `b_q`: 0 keeps it, 1 sets 0xFF, 2 takes `mem_din`, and 3 takes the bitwise inverse of `b_q`. In modes other than 2, `mem_din` has no effect.
- R9: Decrement is an add (`op_sel` = 4) after `b_q` has been filled with ones, so `acc_q` becomes `acc_q`-1 modulo 256 (0x00 gives 0xFF).
- R10: `acc_zero` is 1 exactly when all 8 bits of `acc_q` are 0, and it follows `acc_q` with no added cycle.
- R11: The unused codes `op_sel` = 3 and 7 leave `acc_q` unchanged.
- R12: When `op_sel` and `bmode_sel` change on the same edge, the accumulator uses the `b_q` value from before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| op_sel | input | 3 | Adder operation code |
| bmode_sel | input | 2 | Operand register source mode |
| mem_din | input | 8 | Data word read from memory |
| acc_q | output | 8 | Accumulator value |
| b_q | output | 8 | Operand register value |
| acc_zero | output | 1 | Accumulator is all zeros |

## Verification
Both registers appear directly at the ports, so a wrong operand selection or a broken carry link shows up in `acc_q` one edge after the operation is applied. A dropped inter-slice carry shows only for operands whose low nibble overflows, so the stimulus crosses 0x0F and 0xFF. A wrong operand mode corrupts `b_q` on the next edge. It reaches `acc_q` one edge after that, when an add or load consumes it. The stimulus changes both selects together, so the bench also catches a design that uses the new operand value instead of the old one.

// File: rtl/acc_pkg.sv
package acc_pkg;

  // Adder operation codes; code 3 and 7 are reserved and act as hold
  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_CLR  = 3'd1,
    OP_INC  = 3'd2,
    OP_RSV3 = 3'd3,
    OP_ADD  = 3'd4,
    OP_ADDC = 3'd5,
    OP_LOAD = 3'd6,
    OP_RSV7 = 3'd7
  } acc_op_e;

  // Operand register source modes
  typedef enum logic [1:0] {
    BM_HOLD = 2'd0,
    BM_ONES = 2'd1,
    BM_MEM  = 2'd2,
    BM_INV  = 2'd3
  } bmode_e;

endpackage

// File: rtl/acc_operand_mux.sv
module acc_operand_mux
  import acc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [2:0]   op_sel,
  input  logic [W-1:0] acc_val,
  input  logic [W-1:0] b_val,
  output logic [W-1:0] a_in,
  output logic [W-1:0] b_in,
  output logic         cin
);

  always_comb begin
    // default: hold (A = accumulator, B = 0, carry 0)
    a_in = acc_val;
    b_in = '0;
    cin  = 1'b0;
    case (acc_op_e'(op_sel))
      OP_CLR: begin
        a_in = '0;
      end
      OP_INC: begin
        cin = 1'b1;
      end
      OP_ADD: begin
        b_in = b_val;
      end
      OP_ADDC: begin
        b_in = b_val;
        cin  = 1'b1;
      end
      OP_LOAD: begin
        a_in = '0;
        b_in = b_val;
      end
      default: begin
        a_in = acc_val;
      end
    endcase
  end

endmodule

// File: rtl/acc_nibble_adder.sv
module acc_nibble_adder #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W:0] carry;

  assign carry[0] = cin;

  generate
    for (genvar i = 0; i < W; i++) begin : g_fa
      assign sum[i]     = a[i] ^ b[i] ^ carry[i];
      assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
    end
  endgenerate

  assign cout = carry[W];

endmodule

// File: rtl/acc_breg.sv
module acc_breg
  import acc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic [W-1:0] din,
  output logic [W-1:0] b_q
);

  logic [W-1:0] b_d;
  logic         b_en;

  always_comb begin
    b_en = 1'b1;
    b_d  = b_q;
    case (bmode_e'(mode))
      BM_HOLD: b_en = 1'b0;
      BM_ONES: b_d  = '1;
      BM_MEM:  b_d  = din;
      BM_INV:  b_d  = ~b_q;
      default: b_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_q <= '0;
    end else if (b_en) begin
      b_q <= b_d;
    end
  end

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int NIBBLE_W = 4,
  parameter int NIBBLES  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [2:0]                  op_sel,
  input  logic [1:0]                  bmode_sel,
  input  logic [NIBBLE_W*NIBBLES-1:0] mem_din,
  output logic [NIBBLE_W*NIBBLES-1:0] acc_q,
  output logic [NIBBLE_W*NIBBLES-1:0] b_q,
  output logic                        acc_zero
);

  localparam int W = NIBBLE_W * NIBBLES;

  logic [W-1:0]     a_in;
  logic [W-1:0]     b_in;
  logic             cin;
  logic [W-1:0]     sum;
  logic [NIBBLES:0] slice_c;
  logic [W-1:0]     acc_d;
  logic             acc_en;

  acc_operand_mux #(.W(W)) u_mux (
    .op_sel  (op_sel),
    .acc_val (acc_q),
    .b_val   (b_q),
    .a_in    (a_in),
    .b_in    (b_in),
    .cin     (cin)
  );

  assign slice_c[0] = cin;

  generate
    for (genvar n = 0; n < NIBBLES; n++) begin : g_slice
      acc_nibble_adder #(.W(NIBBLE_W)) u_add (
        .a    (a_in[n*NIBBLE_W +: NIBBLE_W]),
        .b    (b_in[n*NIBBLE_W +: NIBBLE_W]),
        .cin  (slice_c[n]),
        .sum  (sum[n*NIBBLE_W +: NIBBLE_W]),
        .cout (slice_c[n+1])
      );
    end
  endgenerate

  acc_breg #(.W(W)) u_breg (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (bmode_sel),
    .din   (mem_din),
    .b_q   (b_q)
  );

  // accumulator takes the adder sum on every edge; final carry discarded
  always_comb begin
    acc_en = 1'b1;
    acc_d  = sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  assign acc_zero = (acc_q == '0);

  logic unused_cout;
  assign unused_cout = slice_c[NIBBLES];

endmodule

// File: rtl/acc_datapath_chk.sv
module acc_datapath_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   op_sel,
  input logic [1:0]   bmode_sel,
  input logic [W-1:0] mem_din,
  input logic [W-1:0] acc_q,
  input logic [W-1:0] b_q,
  input logic         acc_zero
);

  // R1
  always_comb begin
    if (!rst_n) begin
      reset_state_chk: assert (acc_q == '0 && b_q == '0);
    end
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd0) |=> (acc_q == $past(acc_q)));

  // R3
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd1) |=> (acc_q == '0));

  // R4
  inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd2) |=> (acc_q == W'($past(acc_q) + 1'b1)));

  // R5
  add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd4) |=> (acc_q == W'($past(acc_q) + $past(b_q))));

  // R6
  addc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd5) |=> (acc_q == W'($past(acc_q) + $past(b_q) + 1'b1)));

  // R7
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd6) |=> (acc_q == $past(b_q)));

  // R8
  bones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bmode_sel == 2'd1) |=> (b_q == '1));

  // R8
  bmem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bmode_sel == 2'd2) |=> (b_q == $past(mem_din)));

  // R8
  binv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bmode_sel == 2'd3) |=> (b_q == ~$past(b_q)));

  // R8
  bhold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bmode_sel == 2'd0) |=> $stable(b_q));

  // R10
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_zero == ($countones(acc_q) == 0));

  // R11
  reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd3 || op_sel == 3'd7) |=> $stable(acc_q));

endmodule

bind acc_datapath acc_datapath_chk #(.W(NIBBLE_W * NIBBLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_sel    (op_sel),
  .bmode_sel (bmode_sel),
  .mem_din   (mem_din),
  .acc_q     (acc_q),
  .b_q       (b_q),
  .acc_zero  (acc_zero)
);

// File: tb/acc_datapath_test.sv
module acc_datapath_test;

  localparam int W = 8;

  typedef struct {
    logic [W-1:0] acc;
    logic [W-1:0] b;
    logic         zero;
    string        tag;
  } exp_t;

  logic         clk;
  logic         rst_n;
  logic [2:0]   op_sel;
  logic [1:0]   bmode_sel;
  logic [W-1:0] mem_din;
  logic [W-1:0] acc_q;
  logic [W-1:0] b_q;
  logic         acc_zero;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  exp_t         sb[$];
  logic [W-1:0] m_acc;
  logic [W-1:0] m_b;

  acc_datapath uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_sel    (op_sel),
    .bmode_sel (bmode_sel),
    .mem_din   (mem_din),
    .acc_q     (acc_q),
    .b_q       (b_q),
    .acc_zero  (acc_zero)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic compare(input exp_t e);
    checks++;
    if (acc_q !== e.acc || b_q !== e.b || acc_zero !== e.zero) begin
      errors++;
      $display("FAIL %s: acc=%h b=%h zero=%b expected acc=%h b=%h zero=%b",
               e.tag, acc_q, b_q, acc_zero, e.acc, e.b, e.zero);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the expected outcome
  task automatic step(input logic [2:0] op, input logic [1:0] bm,
                      input logic [W-1:0] din, input string tag);
    logic [W-1:0] na;
    logic [W-1:0] nb;
    exp_t e;
    @(negedge clk);
    op_sel    = op;
    bmode_sel = bm;
    mem_din   = din;
    case (op)
      3'd1:    na = '0;
      3'd2:    na = m_acc + 1'b1;
      3'd4:    na = m_acc + m_b;
      3'd5:    na = m_acc + m_b + 1'b1;
      3'd6:    na = m_b;
      default: na = m_acc;
    endcase
    case (bm)
      2'd1:    nb = '1;
      2'd2:    nb = din;
      2'd3:    nb = ~m_b;
      default: nb = m_b;
    endcase
    m_acc  = na;
    m_b    = nb;
    e.acc  = na;
    e.b    = nb;
    e.zero = (na == '0);
    e.tag  = tag;
    sb.push_back(e);
  endtask

  // monitor: compares after each edge, away from the edge itself
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) compare(sb.pop_front());
    end
  end

  initial begin
    exp_t r;
    rst_n     = 1'b0;
    op_sel    = 3'd0;
    bmode_sel = 2'd0;
    mem_din   = 8'hA5;
    m_acc     = '0;
    m_b       = '0;
    repeat (3) @(negedge clk);
    r.acc = '0; r.b = '0; r.zero = 1'b1; r.tag = "R1 reset";
    compare(r);
    rst_n = 1'b1;

    step(3'd0, 2'd2, 8'h0F, "R8 mem capture / R2 hold");
    step(3'd6, 2'd0, 8'h77, "R7 load");
    step(3'd2, 2'd0, 8'h33, "R4 nibble carry");
    step(3'd1, 2'd0, 8'h00, "R3 clear / R10 zero");
    step(3'd6, 2'd2, 8'hC8, "R12 old operand used");
    step(3'd4, 2'd0, 8'h00, "R5 add");
    step(3'd4, 2'd0, 8'h00, "R5 add carry dropped");
    step(3'd0, 2'd1, 8'h12, "R8 ones");
    step(3'd4, 2'd0, 8'h00, "R9 decrement");
    step(3'd0, 2'd2, 8'h1E, "R8 mem capture");
    step(3'd0, 2'd3, 8'h55, "R8 invert");
    step(3'd5, 2'd0, 8'h00, "R6 subtract");
    step(3'd3, 2'd0, 8'hFF, "R11 code 3");
    step(3'd7, 2'd0, 8'hFF, "R11 code 7");
    step(3'd1, 2'd1, 8'h00, "R3 clear with ones");
    step(3'd4, 2'd0, 8'h00, "R9 decrement wrap");
    step(3'd2, 2'd0, 8'h00, "R4 wrap / R10 zero");
    step(3'd0, 2'd0, 8'h5A, "R8 hold ignores data");
    step(3'd6, 2'd3, 8'hC3, "R12 load before invert");
    step(3'd0, 2'd0, 8'h00, "R2 hold");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: acc=%h b=%h expected run to end", acc_q, b_q);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule